// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a simple byte-wide host bus and a byte-level I2C transaction engine. The host sees an 18-byte window of registers. Most of them are plain storage with fixed write masks. A few have side effects.

- Writing the data register sends a byte, and first opens a write transfer if the bus is idle.
- Writing the control register can open a read transfer.
- Reading the data register while a read is open fetches a byte. A two-bit pending counter in the control register then decides whether the read is closed or restarted for the next byte.
- Status and extended-status flags record address and data acknowledge failures.

The transaction engine is abstract. The block issues start (with a 7-bit target address and a direction), send, receive and stop commands, and each command returns ack or nack. The host bus stalls through a ready signal for as long as a command is outstanding. Bit timing, clock division, slave operation and interrupt generation belong to other blocks.

Top module: `i2cm_reg_ctrl`

## Requirements
- R1: After reset every offset reads 0, with three exceptions. Offset 9 (extended status) reads 0x8F, offset 16 (direct control) reads 0x0F, and offset 0 reads 0xFF.
- R2: The plain offsets (2, 5, 7, 10–14, 16, 17) store written values under fixed masks: 0xDF at offset 7, 0x77 at offset 14, 0x07 at offset 16, and 0xFF at the others. Offsets 1, 3 and 18–31 read 0 and ignore writes.
- R3: A write to status (offset 8) clears only the bits set in value & 0x0A. A write to extended status (offset 9) clears the bits set in value & 0x8F. The status bits are: transfer-in-progress at bit 0, error at bit 2, read-open at bit 5. Extended-status bit 0 is the abort flag.
- R4: A write to offset 15 with bit 0 set restores every register to its reset value and stores nothing. With bit 0 clear, the value is stored.
- R5: Each command is held on cmd_valid with stable fields until rsp_valid is sampled. The cmd_op codes are START=0, SEND=1, RECV=2 and STOP=3. cmd_addr is bits 7:1 of offset 4, and cmd_rd is 1 only for a read start. host_ready stays low while a command is outstanding.
- R6: A data-register write while the bus is idle first issues a write START. On ack, status bit 0 is set, bit 2 is cleared, extended status is zeroed, and a SEND of the byte follows. On nack, bit 0 is cleared, bit 2 and the abort flag are set, and no SEND follows.
- R7: A data-register write while a transfer is open issues only a SEND. A nack on that SEND clears bit 0, sets bit 2 and the abort flag, and issues a STOP.
- R8: Writing offset 4 issues a STOP when a transfer is open and no command when the bus is idle.
- R9: A control write with bits 0 and 1 both set does the following in order:
  - If a transfer is open, it clears status bit 0 and issues a STOP.
  - It then issues a read START.
  - On ack, it sets bit 5, clears bit 2 and zeroes extended status. On nack, it clears bit 0 and sets bit 2 and the abort flag.
  
  A control write with bit 0 set and bit 1 clear only clears status bit 0.
- R10: A data-register read while status bit 5 is clear returns 0xFF and issues no command.
- R11: A data-register read while status bit 5 is set issues RECV. It returns the received byte, or 0xFF when the receive nacks.
- R12: After a receive, the pending count in control bits 5:4 decides what happens next:
  - A count of 0 clears status bit 5 and leaves the count at 0.
  - A nonzero count issues STOP and then a read START with the R9 status updates, and the count becomes one less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request, held until ready is seen |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 5 | Byte offset in the register window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_ready is high |
| host_ready | output | 1 | Access completes at a clock edge with host_sel and host_ready high |
| cmd_valid | output | 1 | Transaction command outstanding |
| cmd_op | output | 2 | Command code (START, SEND, RECV, STOP) |
| cmd_addr | output | 7 | Target address for START |
| cmd_rd | output | 1 | Direction of START, 1 = read |
| cmd_wdata | output | 8 | Byte for SEND |
| rsp_valid | input | 1 | One-cycle response to the outstanding command |
| rsp_nack | input | 1 | Response was a nack |
| rsp_rdata | input | 8 | Received byte for RECV |

## Verification
Plain register accesses finish in the same cycle they are presented: host_ready is high combinationally and the read data is valid at once. Every access that needs the transaction port holds host_ready low:
- one or two cycles per command, as the bench's responder answers;
- one further cycle in which the result is presented.

The host task in the bench waits for ready at each falling edge and captures the read data there. Status and command-log checks run only after the access has completed. The bench responder logs every command at the falling edge where it answers, so each check compares the full ordered command list an access produced.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int OFF_W     = 5;
    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 18;
    localparam int ADDR_W    = 7;

    localparam logic [OFF_W-1:0] OFF_DATA  = 5'd0;
    localparam logic [OFF_W-1:0] OFF_TADDR = 5'd4;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 5'd6;
    localparam logic [OFF_W-1:0] OFF_STAT  = 5'd8;
    localparam logic [OFF_W-1:0] OFF_XSTAT = 5'd9;
    localparam logic [OFF_W-1:0] OFF_XCTRL = 5'd15;

    localparam int ST_XFER = 0;
    localparam int ST_ERR  = 2;
    localparam int ST_RDOP = 5;
    localparam int XS_ABRT = 0;

    localparam logic [DATA_W-1:0] STAT_CLR_MASK  = 8'h0A;
    localparam logic [DATA_W-1:0] XSTAT_CLR_MASK = 8'h8F;
    localparam logic [DATA_W-1:0] XSTAT_RST      = 8'h8F;
    localparam logic [DATA_W-1:0] IDLE_READ      = 8'hFF;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSTART,
        S_WSEND,
        S_STOP,
        S_RSTART,
        S_RECV,
        S_DONE
    } seq_e;

    typedef struct packed {
        logic              wr;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } host_acc_t;

    function automatic logic cfg_plain(input int off);
        case (off)
            2, 5, 7, 10, 11, 12, 13, 14, 15, 16, 17: return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_rst(input int off);
        return (off == 16) ? 8'h0F : 8'h00;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_mask(input int off);
        case (off)
            7:       return 8'hDF;
            14:      return 8'h77;
            16:      return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_cfg_bank.sv
module i2cm_cfg_bank
    import i2cm_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        soft_rst,
    input  logic                        we,
    input  logic [OFF_W-1:0]            off,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NREG-1:0][DATA_W-1:0] cfg
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (cfg_plain(i)) begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    q <= cfg_rst(i);
                end else if (we && off == OFF_W'(i)) begin
                    q <= wdata & cfg_mask(i);
                end
            end
            assign cfg[i] = q;
        end else begin : g_core
            assign cfg[i] = '0;
        end
    end

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              acc_sel,
    input  host_acc_t         acc,
    output logic              acc_ready,
    output logic              simple_go,
    output logic              seq_done,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] taddr,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] stat,
    output logic [DATA_W-1:0] xstat,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_rd,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [DATA_W-1:0] rsp_rdata
);

    seq_e              state_q, stop_next_q;
    logic              active_q;
    logic [DATA_W-1:0] txd_q, rbyte_q, taddr_q, ctrl_q, stat_q, xstat_q;

    logic              needs_seq;
    seq_e              first_st, after_stop;
    logic [1:0]        pend;

    assign pend = ctrl_q[5:4];

    always_comb begin
        needs_seq  = 1'b0;
        first_st   = S_IDLE;
        after_stop = S_DONE;
        if (acc.wr) begin
            case (acc.off)
                OFF_DATA: begin
                    needs_seq = 1'b1;
                    first_st  = active_q ? S_WSEND : S_WSTART;
                end
                OFF_TADDR: begin
                    if (active_q) begin
                        needs_seq = 1'b1;
                        first_st  = S_STOP;
                    end
                end
                OFF_CTRL: begin
                    if (acc.data[0] && acc.data[1]) begin
                        needs_seq  = 1'b1;
                        first_st   = active_q ? S_STOP : S_RSTART;
                        after_stop = S_RSTART;
                    end
                end
                default: ;
            endcase
        end else if (acc.off == OFF_DATA && stat_q[ST_RDOP]) begin
            needs_seq = 1'b1;
            first_st  = S_RECV;
        end
    end

    assign acc_ready = (state_q == S_IDLE && !needs_seq) || state_q == S_DONE;
    assign simple_go = acc_sel && state_q == S_IDLE && !needs_seq;
    assign seq_done  = state_q == S_DONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            stop_next_q <= S_DONE;
            active_q    <= 1'b0;
            txd_q       <= '0;
            rbyte_q     <= '0;
            taddr_q     <= '0;
            ctrl_q      <= '0;
            stat_q      <= '0;
            xstat_q     <= XSTAT_RST;
        end else if (soft_rst) begin
            txd_q   <= '0;
            taddr_q <= '0;
            ctrl_q  <= '0;
            stat_q  <= '0;
            xstat_q <= XSTAT_RST;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (acc_sel) begin
                        if (acc.wr) begin
                            case (acc.off)
                                OFF_DATA:  txd_q   <= acc.data;
                                OFF_TADDR: taddr_q <= acc.data;
                                OFF_CTRL: begin
                                    ctrl_q <= acc.data;
                                    if (acc.data[0] && (!acc.data[1] || active_q))
                                        stat_q[ST_XFER] <= 1'b0;
                                end
                                OFF_STAT:  stat_q  <= stat_q & ~(acc.data & STAT_CLR_MASK);
                                OFF_XSTAT: xstat_q <= xstat_q & ~(acc.data & XSTAT_CLR_MASK);
                                default: ;
                            endcase
                        end
                        if (needs_seq) begin
                            state_q     <= first_st;
                            stop_next_q <= after_stop;
                        end
                    end
                end
                S_WSTART: begin
                    if (rsp_valid) begin
                        if (rsp_nack) begin
                            stat_q[ST_XFER]  <= 1'b0;
                            stat_q[ST_ERR]   <= 1'b1;
                            xstat_q[XS_ABRT] <= 1'b1;
                            active_q         <= 1'b0;
                            state_q          <= S_DONE;
                        end else begin
                            stat_q[ST_XFER] <= 1'b1;
                            stat_q[ST_ERR]  <= 1'b0;
                            xstat_q         <= '0;
                            active_q        <= 1'b1;
                            state_q         <= S_WSEND;
                        end
                    end
                end
                S_WSEND: begin
                    if (rsp_valid) begin
                        if (rsp_nack) begin
                            stat_q[ST_XFER]  <= 1'b0;
                            stat_q[ST_ERR]   <= 1'b1;
                            xstat_q[XS_ABRT] <= 1'b1;
                            stop_next_q      <= S_DONE;
                            state_q          <= S_STOP;
                        end else begin
                            state_q <= S_DONE;
                        end
                    end
                end
                S_STOP: begin
                    if (rsp_valid) begin
                        active_q <= 1'b0;
                        state_q  <= stop_next_q;
                    end
                end
                S_RSTART: begin
                    if (rsp_valid) begin
                        if (rsp_nack) begin
                            stat_q[ST_XFER]  <= 1'b0;
                            stat_q[ST_ERR]   <= 1'b1;
                            xstat_q[XS_ABRT] <= 1'b1;
                            active_q         <= 1'b0;
                        end else begin
                            stat_q[ST_RDOP] <= 1'b1;
                            stat_q[ST_ERR]  <= 1'b0;
                            xstat_q         <= '0;
                            active_q        <= 1'b1;
                        end
                        state_q <= S_DONE;
                    end
                end
                S_RECV: begin
                    if (rsp_valid) begin
                        rbyte_q <= rsp_nack ? IDLE_READ : rsp_rdata;
                        if (pend == 2'd0) begin
                            stat_q[ST_RDOP] <= 1'b0;
                            state_q         <= S_DONE;
                        end else begin
                            ctrl_q[5:4] <= pend - 2'd1;
                            stop_next_q <= S_RSTART;
                            state_q     <= S_STOP;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
        cmd_rd    = 1'b0;
        case (state_q)
            S_WSTART: cmd_op = OP_START;
            S_WSEND:  cmd_op = OP_SEND;
            S_STOP:   cmd_op = OP_STOP;
            S_RSTART: begin
                cmd_op = OP_START;
                cmd_rd = 1'b1;
            end
            S_RECV:   cmd_op = OP_RECV;
            default:  cmd_valid = 1'b0;
        endcase
    end

    assign cmd_addr  = taddr_q[7:1];
    assign cmd_wdata = txd_q;
    assign rd_byte   = rbyte_q;
    assign taddr     = taddr_q;
    assign ctrl      = ctrl_q;
    assign stat      = stat_q;
    assign xstat     = xstat_q;

    // R5: command held steady until answered
    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));

    // R5: host stalled while a command is outstanding
    p_busy_stall_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !acc_ready);

    // R6: address nack on write start raises error flags
    p_wstart_nack_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WSTART && rsp_valid && rsp_nack) |=>
        (stat_q[ST_ERR] && !stat_q[ST_XFER] && xstat_q[XS_ABRT] && !cmd_valid));

    // R12: last byte closes the read without wrapping the count
    p_last_byte_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RECV && rsp_valid && pend == 2'd0) |=>
        (!stat_q[ST_RDOP] && ctrl_q[5:4] == 2'd0));

    // R12: a pending byte decrements the count and stops the bus
    p_pend_step_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RECV && rsp_valid && pend != 2'd0) |=>
        (ctrl_q[5:4] == $past(pend) - 2'd1 && cmd_valid && cmd_op == OP_STOP));

    // R10: data read with no open read finishes at once and issues nothing
    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_sel && !acc.wr && acc.off == OFF_DATA && state_q == S_IDLE && !stat_q[ST_RDOP])
        |-> acc_ready);

endmodule

// File: rtl/i2cm_reg_ctrl.sv
module i2cm_reg_ctrl
    import i2cm_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_rd,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [DATA_W-1:0] rsp_rdata
);

    host_acc_t                  acc;
    logic                       simple_go, seq_done, soft_rst, cfg_we;
    logic [DATA_W-1:0]          rd_byte, taddr, ctrl, stat, xstat;
    logic [NREG-1:0][DATA_W-1:0] cfg;
    op_e                        op;

    assign acc.wr   = host_wr;
    assign acc.off  = host_off;
    assign acc.data = host_wdata;

    assign soft_rst = simple_go && host_wr && host_off == OFF_XCTRL && host_wdata[0];
    assign cfg_we   = simple_go && host_wr && !soft_rst;

    i2cm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .acc_sel   (host_sel),
        .acc       (acc),
        .acc_ready (host_ready),
        .simple_go (simple_go),
        .seq_done  (seq_done),
        .rd_byte   (rd_byte),
        .taddr     (taddr),
        .ctrl      (ctrl),
        .stat      (stat),
        .xstat     (xstat),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .cmd_addr  (cmd_addr),
        .cmd_rd    (cmd_rd),
        .cmd_wdata (cmd_wdata),
        .rsp_valid (rsp_valid),
        .rsp_nack  (rsp_nack),
        .rsp_rdata (rsp_rdata)
    );

    assign cmd_op = op;

    i2cm_cfg_bank #(.NREG(NREG)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .we       (cfg_we),
        .off      (host_off),
        .wdata    (host_wdata),
        .cfg      (cfg)
    );

    always_comb begin
        host_rdata = '0;
        if (seq_done) begin
            host_rdata = rd_byte;
        end else begin
            case (host_off)
                OFF_DATA:  host_rdata = IDLE_READ;
                OFF_TADDR: host_rdata = taddr;
                OFF_CTRL:  host_rdata = ctrl;
                OFF_STAT:  host_rdata = stat;
                OFF_XSTAT: host_rdata = xstat;
                default: begin
                    for (int i = 0; i < NREG; i++) begin
                        if (host_off == OFF_W'(i)) host_rdata = cfg[i];
                    end
                end
            endcase
        end
    end

endmodule

// File: tb/tb_i2cm_reg_ctrl.sv
module tb_i2cm_reg_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [4:0] host_off = '0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       host_ready;
    logic       cmd_valid, cmd_rd;
    logic [1:0] cmd_op;
    logic [6:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       rsp_valid = 1'b0, rsp_nack = 1'b0;
    logic [7:0] rsp_rdata = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [1:0] lg_op   [64];
    logic [6:0] lg_addr [64];
    logic       lg_rd   [64];
    logic [7:0] lg_dat  [64];
    int         log_n = 0;
    logic [6:0] good_addr = 7'h50;
    logic [7:0] rx_next = 8'h40;
    logic       recv_fail = 1'b0;
    logic [7:0] model [32];

    always #4 clk = ~clk;

    i2cm_reg_ctrl dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata)
    );

    // target model: answers each command at a falling edge
    always @(negedge clk) begin
        if (rsp_valid) begin
            rsp_valid = 1'b0;
        end else if (cmd_valid) begin
            if (log_n < 64) begin
                lg_op[log_n]   = cmd_op;
                lg_addr[log_n] = cmd_addr;
                lg_rd[log_n]   = cmd_rd;
                lg_dat[log_n]  = cmd_wdata;
            end
            log_n++;
            rsp_nack  = 1'b0;
            rsp_rdata = 8'h00;
            case (cmd_op)
                2'd0: rsp_nack = (cmd_addr != good_addr);
                2'd1: rsp_nack = (cmd_wdata == 8'hEE);
                2'd2: begin
                    rsp_nack  = recv_fail;
                    rsp_rdata = rx_next;
                    rx_next   = rx_next + 8'd1;
                end
                default: ;
            endcase
            rsp_valid = 1'b1;
        end
    end

    function automatic logic [7:0] bmask(input int off);
        case (off)
            7:       return 8'hDF;
            14:      return 8'h77;
            16:      return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] brst(input int off);
        case (off)
            0:       return 8'hFF;
            9:       return 8'h8F;
            16:      return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit bplain(input int off);
        return off == 2 || off == 5 || off == 7 || (off >= 10 && off <= 17);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] o, input logic [7:0] d,
                       output logic [7:0] r);
        @(negedge clk);
        host_sel = 1'b1; host_wr = w; host_off = o; host_wdata = d;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        r = host_rdata;
        @(posedge clk);
        #1;
        host_sel = 1'b0;
    endtask

    task automatic wr(input logic [4:0] o, input logic [7:0] d);
        logic [7:0] r;
        acc(1'b1, o, d, r);
    endtask

    task automatic rdchk(input string req, input logic [4:0] o, input logic [7:0] e);
        logic [7:0] r;
        acc(1'b0, o, 8'h00, r);
        chk(req, r, e);
    endtask

    task automatic logchk(input string req, input int i, input logic [1:0] op,
                          input logic [6:0] a, input logic rd, input logic [7:0] dat);
        logic [17:0] got, exp;
        got = {lg_op[i], lg_addr[i], lg_rd[i], (op == 2'd1) ? lg_dat[i] : 8'h00};
        exp = {op, (op == 2'd0) ? a : lg_addr[i], rd, (op == 2'd1) ? dat : 8'h00};
        chk(req, got, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values, R10 idle data read issues nothing
        for (int o = 0; o < 32; o++) rdchk("R1", 5'(o), brst(o));
        chk("R10 no command", log_n, 0);

        // R2 random plain writes against mask model
        for (int o = 0; o < 32; o++) model[o] = brst(o);
        for (int k = 0; k < 60; k++) begin
            int o;
            o = $urandom_range(0, 31);
            v = 8'($urandom);
            if (o == 15) v[0] = 1'b0;
            if (bplain(o)) begin
                wr(5'(o), v);
                model[o] = v & bmask(o);
                rdchk("R2 plain", 5'(o), model[o]);
            end else if (o == 1 || o == 3 || o >= 18) begin
                wr(5'(o), v);
                rdchk("R2 unmapped", 5'(o), 8'h00);
            end
        end
        for (int o = 0; o < 32; o++) if (bplain(o)) rdchk("R2 final", 5'(o), model[o]);
        chk("R2 no command", log_n, 0);

        // R4 offset 15 stores with bit0 clear, soft reset with bit0 set
        wr(5'd15, 8'h5A);
        rdchk("R4 store", 5'd15, 8'h5A);
        wr(5'd9, 8'h0F);
        rdchk("R3 xstat clear", 5'd9, 8'h80);
        wr(5'd6, 8'h30);
        wr(5'd4, 8'h44);
        wr(5'd15, 8'h01);
        for (int o = 1; o < 32; o++) rdchk("R4 soft reset", 5'(o), brst(o));

        // R6 idle data write: start then send
        wr(5'd4, 8'hA0);
        log_n = 0;
        wr(5'd0, 8'h12);
        chk("R6 count", log_n, 2);
        logchk("R6 start", 0, 2'd0, 7'h50, 1'b0, 8'h00);
        logchk("R6 send", 1, 2'd1, 7'h50, 1'b0, 8'h12);
        rdchk("R6 stat", 5'd8, 8'h01);
        rdchk("R6 xstat", 5'd9, 8'h00);

        // R7 open transfer: send only
        log_n = 0;
        wr(5'd0, 8'h34);
        chk("R7 count", log_n, 1);
        logchk("R7 send", 0, 2'd1, 7'h50, 1'b0, 8'h34);

        // R7 data nack
        log_n = 0;
        wr(5'd0, 8'hEE);
        chk("R7 nack count", log_n, 2);
        logchk("R7 stop", 1, 2'd3, 7'h50, 1'b0, 8'h00);
        rdchk("R7 stat", 5'd8, 8'h04);
        rdchk("R7 xstat", 5'd9, 8'h01);
        wr(5'd8, 8'hFF);
        rdchk("R3 stat mask", 5'd8, 8'h04);

        // R8 idle address write, R6 address nack
        log_n = 0;
        wr(5'd4, 8'hA2);
        chk("R8 idle", log_n, 0);
        wr(5'd9, 8'h8F);
        rdchk("R3 xstat all", 5'd9, 8'h00);
        wr(5'd0, 8'h55);
        chk("R6 nack count", log_n, 1);
        logchk("R6 nack start", 0, 2'd0, 7'h51, 1'b0, 8'h00);
        rdchk("R6 nack xstat", 5'd9, 8'h01);
        rdchk("R6 nack stat", 5'd8, 8'h04);

        // R8 address write while open
        wr(5'd4, 8'hA0);
        wr(5'd0, 8'h01);
        rdchk("R6 stat ack", 5'd8, 8'h01);
        log_n = 0;
        wr(5'd4, 8'hA0);
        chk("R8 count", log_n, 1);
        logchk("R8 stop", 0, 2'd3, 7'h50, 1'b0, 8'h00);

        // R9 read start from idle, pending 2
        log_n = 0;
        wr(5'd6, 8'h23);
        chk("R9 count", log_n, 1);
        logchk("R9 start", 0, 2'd0, 7'h50, 1'b1, 8'h00);
        rdchk("R9 stat", 5'd8, 8'h21);
        rdchk("R9 ctrl", 5'd6, 8'h23);

        // R11 R12 multi-byte read
        log_n = 0;
        rdchk("R11 byte0", 5'd0, 8'h40);
        chk("R12 count", log_n, 3);
        logchk("R12 recv", 0, 2'd2, 7'h50, 1'b0, 8'h00);
        logchk("R12 stop", 1, 2'd3, 7'h50, 1'b0, 8'h00);
        logchk("R12 restart", 2, 2'd0, 7'h50, 1'b1, 8'h00);
        rdchk("R12 ctrl 1", 5'd6, 8'h13);
        rdchk("R11 byte1", 5'd0, 8'h41);
        rdchk("R12 ctrl 0", 5'd6, 8'h03);
        log_n = 0;
        rdchk("R11 byte2", 5'd0, 8'h42);
        chk("R12 last count", log_n, 1);
        rdchk("R12 ctrl stays", 5'd6, 8'h03);
        rdchk("R12 stat", 5'd8, 8'h01);
        log_n = 0;
        rdchk("R10 closed", 5'd0, 8'hFF);
        chk("R10 count", log_n, 0);

        // R9 read start while open
        log_n = 0;
        wr(5'd6, 8'h03);
        chk("R9 open count", log_n, 2);
        logchk("R9 open stop", 0, 2'd3, 7'h50, 1'b0, 8'h00);
        logchk("R9 open start", 1, 2'd0, 7'h50, 1'b1, 8'h00);
        rdchk("R9 open stat", 5'd8, 8'h20);

        // R11 receive failure
        recv_fail = 1'b1;
        rdchk("R11 fail", 5'd0, 8'hFF);
        recv_fail = 1'b0;
        rdchk("R11 stat", 5'd8, 8'h00);

        // R9 transfer bit only
        wr(5'd4, 8'hA0);
        wr(5'd0, 8'h77);
        rdchk("R9 pre", 5'd8, 8'h01);
        log_n = 0;
        wr(5'd6, 8'h01);
        chk("R9 pt count", log_n, 0);
        rdchk("R9 pt stat", 5'd8, 8'h00);
        rdchk("R9 pt ctrl", 5'd6, 8'h01);

        // R9 read start nack
        wr(5'd4, 8'hB0);
        log_n = 0;
        wr(5'd6, 8'h03);
        chk("R9 nack count", log_n, 1);
        logchk("R9 nack start", 0, 2'd0, 7'h58, 1'b1, 8'h00);
        rdchk("R9 nack stat", 5'd8, 8'h04);
        rdchk("R9 nack xstat", 5'd9, 8'h01);
        // R5: command port address tracks offset 4
        chk("R5 addr", lg_addr[0], 7'h58);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule